// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Dispatcher

This block arbitrates five interrupt sources for a small 8-bit processor core. Each source has a request line that latches into a byte-wide flag register. A byte-wide enable register masks the flags, and a single master-enable bit gates the whole scheme. The core raises a strobe at each instruction boundary. At that strobe the dispatcher checks whether anything enabled is pending. If so, it services exactly one source: the lowest-numbered qualifying one. Servicing clears that source's flag and drops the master enable. It also wakes the core from its halt state and presents a one-cycle take pulse with the source's restart address.

The core reads and writes both registers as whole bytes through a simple address/data port. It raises or lowers the master enable through two control inputs and enters the halt state through a third. Pushing the return address and re-enabling interrupts afterwards stay with the core. A check that finds enabled pending bits only above the five real sources still wakes the core, but it services nothing and leaves the master enable set.

Top module: `irq_dispatch`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0x00, the master enable and the halt state are 0, take_o is 0 and vector_o is 0x00.
- R2: The enable register is at address 0xFFFF and the flag register at 0xFF0F. Both are written and read as whole 8-bit bytes. A write to any other address changes nothing, and a read from any other address returns 0x00.
- R3: A high src_req[k] sets flag bit k at the next clock edge. When a flag-register write happens in the same cycle, the written byte replaces the old value first and the requested bits are then OR-ed in.
- R4: A check happens only in a cycle with insn_done high, master enable set and a nonzero bitwise AND of all eight bits of the enable and flag registers. No take occurs otherwise.
- R5: Priority follows bit index, bit 0 highest and bit 4 lowest, and a single check services one source only.
- R6: The vector for source k is 0x40 + 8*k (0x40, 0x48, 0x50, 0x58, 0x60). vector_o is 0x00 whenever take_o is low.
- R7: Servicing clears only the serviced source's flag bit; other pending flag bits stay set.
- R8: take_o pulses for exactly one cycle, the cycle after the qualifying strobe. In that cycle the master enable and the halt state read 0.
- R9: A check whose enabled pending bits all lie in bits 5 to 7 produces no take and clears the halt state, but leaves the master enable set.
- R10: ime_set raises and ime_clr lowers the master enable, and halt_req enters the halt state. A check in the same cycle overrides ime_set and halt_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| src_req | input | 5 | Per-source request lines |
| insn_done | input | 1 | Instruction-boundary strobe |
| ime_set | input | 1 | Raise master enable |
| ime_clr | input | 1 | Lower master enable |
| halt_req | input | 1 | Enter halt state |
| take_o | output | 1 | One-cycle interrupt-taken pulse |
| vector_o | output | 8 | Restart vector, valid with take_o |
| ime_o | output | 1 | Current master enable |
| halted_o | output | 1 | Current halt state |

## Verification
The bench puts several sources pending at once and then dispatches repeatedly. A broken priority chain would service the wrong source first. A broken clear mask would leave the serviced flag set or wipe its neighbours, and the flag readback would show it. The bench runs checks with the master enable low, with enabled and pending bits that do not overlap, and with no strobe at all. A gating error in any of these cases shows up as a take pulse with no expected vector waiting in the scoreboard. The bench also places enabled pending bits only in bits 5 to 7, and raises ime_set and halt_req in the same cycle as a check. A design that mishandles these would lose the master enable, keep the core halted, or let the control input win over the dispatch.

// File: rtl/irqd_pkg.sv
// Package: shared types for the interrupt dispatcher.
// Assumes: nothing beyond IEEE 1800-2017.
package irqd_pkg;

    // Which architectural register an access decodes to.
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_EN   = 2'd1,
        RSEL_FLAG = 2'd2
    } rsel_e;

endpackage

// File: rtl/irqd_regs.sv
// Module: enable and flag registers with byte access.
// Holds both byte-wide registers, decodes the access address, sets flag
// bits from source requests and clears the bits granted by the dispatcher.
// Assumes: requests, writes and the clear mask may coincide; a write wins
// over the clear, and requests are OR-ed in last.
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 16,
    parameter int          NUM_SRC   = 5,
    parameter logic [15:0] EN_ADDR   = 16'hFFFF,
    parameter logic [15:0] FLAG_ADDR = 16'hFF0F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [DATA_W-1:0]  en_q,
    output logic [DATA_W-1:0]  flag_q,
    output logic [DATA_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

    rsel_e             sel;
    logic [DATA_W-1:0] req_w;
    logic [DATA_W-1:0] clr_w;
    logic [DATA_W-1:0] flag_base;
    logic [DATA_W-1:0] flag_d;

    // Decode the access address into a register select.
    always_comb begin
        if (addr == EN_A)
            sel = RSEL_EN;
        else if (addr == FLAG_A)
            sel = RSEL_FLAG;
        else
            sel = RSEL_NONE;
    end

    assign req_w = DATA_W'(src_req);
    assign clr_w = DATA_W'(clr_mask);

    // Next flag value: write replaces, else clear granted bit; then OR requests.
    always_comb begin
        if (wr_en && sel == RSEL_FLAG)
            flag_base = wdata;
        else
            flag_base = flag_q & ~clr_w;
        flag_d = flag_base | req_w;
    end

    // Enable register: whole-byte write only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en && sel == RSEL_EN)
            en_q <= wdata;
    end

    // Flag register: update every cycle from the merged next value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= flag_d;
    end

    // Read mux: unmapped addresses read as zero.
    always_comb begin
        unique case (sel)
            RSEL_EN:   rdata = en_q;
            RSEL_FLAG: rdata = flag_q;
            default:   rdata = '0;
        endcase
    end

    AST_OTHER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RSEL_NONE) |=> $stable(en_q)); // R2

    AST_EN_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RSEL_EN) |=> (en_q == $past(wdata))); // R2

    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_req_chk
            AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                src_req[k] |=> flag_q[k]); // R3
        end
    endgenerate

endmodule

// File: rtl/irqd_prio.sv
// Module: fixed-priority selector.
// Grants the lowest-index asserted request and reports its index.
// Assumes: bit 0 is the highest priority; purely combinational.
module irqd_prio #(
    parameter int NUM_SRC = 5,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    logic [NUM_SRC:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
            assign grant[i]    = req[i] & ~seen[i];
            assign seen[i+1]   = seen[i] | req[i];
        end
    endgenerate

    assign any = seen[NUM_SRC];

    // Encode the granted position as a binary index.
    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (grant[i])
                idx = IDX_W'(i);
        end
    end

    // Grant is never more than one source.
    always_comb begin
        if (!$isunknown(req))
            AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R5
    end

endmodule

// File: rtl/irqd_ctrl.sv
// Module: dispatch control.
// Owns the master enable, the halt state, and the registered take pulse
// and vector. A check fires on an instruction-boundary strobe when the
// master enable is set and any enabled flag is pending.
// Assumes: the selector's grant comes from bits that are both enabled
// and pending; the vector table is linear in the source index.
module irqd_ctrl #(
    parameter int          DATA_W   = 8,
    parameter int          NUM_SRC  = 5,
    parameter int          IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    parameter logic [7:0]  VEC_BASE = 8'h40,
    parameter logic [7:0]  VEC_STEP = 8'h08
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_done,
    input  logic               ime_set,
    input  logic               ime_clr,
    input  logic               halt_req,
    input  logic               pend_any,
    input  logic               sel_any,
    input  logic [IDX_W-1:0]   sel_idx,
    input  logic [NUM_SRC-1:0] sel_grant,
    output logic [NUM_SRC-1:0] clr_mask,
    output logic               take,
    output logic [DATA_W-1:0]  vector,
    output logic               ime,
    output logic               halted
);

    localparam logic [DATA_W-1:0] BASE_W = DATA_W'(VEC_BASE);
    localparam logic [DATA_W-1:0] STEP_W = DATA_W'(VEC_STEP);
    localparam logic [DATA_W-1:0] LAST_W = BASE_W + STEP_W * DATA_W'(NUM_SRC - 1);

    logic              fire;
    logic              serve;
    logic [DATA_W-1:0] vec_calc;

    // A check happens at the boundary when enabled and something is pending.
    assign fire  = insn_done && ime && pend_any;
    assign serve = fire && sel_any;

    // Clear exactly the granted flag bit when a source is serviced.
    assign clr_mask = serve ? sel_grant : '0;

    // Restart address for the selected source.
    assign vec_calc = BASE_W + STEP_W * DATA_W'(sel_idx);

    // Master enable: a check drops it, restoring it if nothing was served.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ime <= 1'b0;
        else if (fire)
            ime <= !sel_any;
        else if (ime_clr)
            ime <= 1'b0;
        else if (ime_set)
            ime <= 1'b1;
    end

    // Halt state: any check wakes the core; otherwise halt_req enters it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (fire)
            halted <= 1'b0;
        else if (halt_req)
            halted <= 1'b1;
    end

    // Registered take pulse and vector, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take   <= 1'b0;
            vector <= '0;
        end else begin
            take   <= serve;
            vector <= serve ? vec_calc : '0;
        end
    end

    AST_TAKE_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($past(insn_done) && $past(ime))); // R4

    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take); // R8

    AST_TAKE_DROPS_IME: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !ime); // R8

    AST_TAKE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !halted); // R8

    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> (vector == '0)); // R6

    AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (vector >= BASE_W && vector <= LAST_W && vector[2:0] == 3'b000)); // R6

    AST_EMPTY_CHECK_KEEPS_IME: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !sel_any) |=> (ime && !take && !halted)); // R9

endmodule

// File: rtl/irq_dispatch.sv
// Module: top of the prioritized vectored interrupt dispatcher.
// Connects the register file, the fixed-priority selector and the
// dispatch control.
// Assumes: one check per insn_done strobe; the core pushes its return
// address and re-enables interrupts on its own.
module irq_dispatch #(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 16,
    parameter int          NUM_SRC   = 5,
    parameter logic [15:0] EN_ADDR   = 16'hFFFF,
    parameter logic [15:0] FLAG_ADDR = 16'hFF0F,
    parameter logic [7:0]  VEC_BASE  = 8'h40,
    parameter logic [7:0]  VEC_STEP  = 8'h08
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               insn_done,
    input  logic               ime_set,
    input  logic               ime_clr,
    input  logic               halt_req,
    output logic               take_o,
    output logic [DATA_W-1:0]  vector_o,
    output logic               ime_o,
    output logic               halted_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [DATA_W-1:0]  en_q;
    logic [DATA_W-1:0]  flag_q;
    logic [DATA_W-1:0]  pend_w;
    logic [NUM_SRC-1:0] pend_src;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] clr_mask;
    logic [IDX_W-1:0]   sel_idx;
    logic               sel_any;
    logic               pend_any;

    // Enabled-and-pending bits over the full byte and over the real sources.
    assign pend_w   = en_q & flag_q;
    assign pend_any = |pend_w;
    assign pend_src = pend_w[NUM_SRC-1:0];

    irqd_regs #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .NUM_SRC   (NUM_SRC),
        .EN_ADDR   (EN_ADDR),
        .FLAG_ADDR (FLAG_ADDR)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .src_req  (src_req),
        .clr_mask (clr_mask),
        .en_q     (en_q),
        .flag_q   (flag_q),
        .rdata    (reg_rdata)
    );

    irqd_prio #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) prio_i (
        .req   (pend_src),
        .grant (grant),
        .idx   (sel_idx),
        .any   (sel_any)
    );

    irqd_ctrl #(
        .DATA_W   (DATA_W),
        .NUM_SRC  (NUM_SRC),
        .IDX_W    (IDX_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .ime_set   (ime_set),
        .ime_clr   (ime_clr),
        .halt_req  (halt_req),
        .pend_any  (pend_any),
        .sel_any   (sel_any),
        .sel_idx   (sel_idx),
        .sel_grant (grant),
        .clr_mask  (clr_mask),
        .take      (take_o),
        .vector    (vector_o),
        .ime       (ime_o),
        .halted    (halted_o)
    );

    AST_SERVED_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0 && !reg_wr_en && (src_req & clr_mask) == '0)
            |=> ((flag_q[NUM_SRC-1:0] & $past(clr_mask)) == '0)); // R7

endmodule

// File: tb/irq_dispatch_tb.sv
// Bench: scoreboard of expected vectors; a monitor compares take pulses.
module irq_dispatch_tb_top;

    localparam logic [15:0] A_EN   = 16'hFFFF;
    localparam logic [15:0] A_FLAG = 16'hFF0F;

    logic        clk;
    logic        rst_n;
    logic        reg_wr_en;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [4:0]  src_req;
    logic        insn_done;
    logic        ime_set;
    logic        ime_clr;
    logic        halt_req;
    logic        take_o;
    logic [7:0]  vector_o;
    logic        ime_o;
    logic        halted_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    irq_dispatch dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_req   (src_req),
        .insn_done (insn_done),
        .ime_set   (ime_set),
        .ime_clr   (ime_clr),
        .halt_req  (halt_req),
        .take_o    (take_o),
        .vector_o  (vector_o),
        .ime_o     (ime_o),
        .halted_o  (halted_o)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic step(input logic with_ime, input logic with_halt);
        @(negedge clk);
        insn_done = 1'b1; ime_set = with_ime; halt_req = with_halt;
        @(negedge clk);
        insn_done = 1'b0; ime_set = 1'b0; halt_req = 1'b0;
    endtask

    task automatic step_expect(input logic [7:0] vec);
        exp_q.push_back(vec);
        step(1'b0, 1'b0);
    endtask

    task automatic pulse_ime_set();
        @(negedge clk); ime_set = 1'b1;
        @(negedge clk); ime_set = 1'b0;
    endtask

    // Monitor: each take pulse must match the oldest expected vector.
    always @(negedge clk) begin
        if (rst_n && take_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected take actual 0x%02h expected none", vector_o);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (vector_o !== e) begin
                    errors++;
                    $display("FAIL R5/R6 vector actual 0x%02h expected 0x%02h", vector_o, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 50000);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        src_req = '0; insn_done = 1'b0; ime_set = 1'b0; ime_clr = 1'b0; halt_req = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_EN, d);   chk("R1 enable reg", d, 8'h00);
        rd(A_FLAG, d); chk("R1 flag reg", d, 8'h00);
        chk("R1 ime", {7'd0, ime_o}, 8'h00);
        chk("R1 halted", {7'd0, halted_o}, 8'h00);
        chk("R1 take", {7'd0, take_o}, 8'h00);
        chk("R1 vector", vector_o, 8'h00);

        // R2: byte access and unmapped addresses
        wr(A_EN, 8'h1F);   rd(A_EN, d);   chk("R2 enable readback", d, 8'h1F);
        wr(A_FLAG, 8'hA5); rd(A_FLAG, d); chk("R2 flag readback", d, 8'hA5);
        wr(16'h1234, 8'hFF);
        rd(A_EN, d);   chk("R2 other write enable", d, 8'h1F);
        rd(A_FLAG, d); chk("R2 other write flag", d, 8'hA5);
        rd(16'h1234, d); chk("R2 other read", d, 8'h00);

        // R3: requests set flags; write first then OR
        wr(A_FLAG, 8'h00);
        @(negedge clk); src_req = 5'b01000;
        @(negedge clk); src_req = '0;
        rd(A_FLAG, d); chk("R3 request sets bit3", d, 8'h08);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = A_FLAG; reg_wdata = 8'h01; src_req = 5'b00100;
        @(negedge clk);
        reg_wr_en = 1'b0; src_req = '0;
        rd(A_FLAG, d); chk("R3 write plus request", d, 8'h05);

        // R4: master enable low blocks the check
        step(1'b0, 1'b0);
        chk("R4 no take with ime low", {7'd0, take_o}, 8'h00);
        rd(A_FLAG, d); chk("R4 flags kept with ime low", d, 8'h05);

        // R5, R7, R8: priority, single service, clear only served bit
        pulse_ime_set();
        chk("R10 ime_set raises", {7'd0, ime_o}, 8'h01);
        step_expect(8'h40);
        chk("R8 take high after strobe", {7'd0, take_o}, 8'h01);
        chk("R8 ime dropped", {7'd0, ime_o}, 8'h00);
        rd(A_FLAG, d); chk("R7 only bit0 cleared", d, 8'h04);
        @(negedge clk);
        chk("R8 take one cycle", {7'd0, take_o}, 8'h00);
        pulse_ime_set();
        step_expect(8'h50);
        rd(A_FLAG, d); chk("R5 next source served", d, 8'h00);

        // R6: every vector
        for (int k = 0; k < 5; k++) begin
            wr(A_FLAG, 8'(1 << k));
            pulse_ime_set();
            step_expect(8'h40 + 8'(8 * k));
            rd(A_FLAG, d); chk("R6 flag cleared after vector", d, 8'h00);
        end

        // R5, R7: all pending, one at a time
        wr(A_FLAG, 8'h1E);
        pulse_ime_set();
        step_expect(8'h48);
        rd(A_FLAG, d); chk("R7 others kept", d, 8'h1C);

        // R8: wake from halt
        wr(A_FLAG, 8'h10);
        @(negedge clk); halt_req = 1'b1;
        @(negedge clk); halt_req = 1'b0;
        chk("R10 halt entered", {7'd0, halted_o}, 8'h01);
        pulse_ime_set();
        step_expect(8'h60);
        chk("R8 halt cleared", {7'd0, halted_o}, 8'h00);

        // R4: enable and flag do not overlap
        wr(A_EN, 8'h02); wr(A_FLAG, 8'h01);
        pulse_ime_set();
        step(1'b0, 1'b0);
        chk("R4 no overlap no take", {7'd0, take_o}, 8'h00);
        chk("R4 ime kept", {7'd0, ime_o}, 8'h01);

        // R4: no strobe, no take
        wr(A_EN, 8'h01);
        repeat (3) @(negedge clk);
        chk("R4 no strobe no take", {7'd0, take_o}, 8'h00);
        rd(A_FLAG, d); chk("R4 flag kept without strobe", d, 8'h01);

        // R9: only upper bits pending
        wr(A_EN, 8'hE0); wr(A_FLAG, 8'h20);
        @(negedge clk); halt_req = 1'b1;
        @(negedge clk); halt_req = 1'b0;
        step(1'b0, 1'b0);
        chk("R9 no take", {7'd0, take_o}, 8'h00);
        chk("R9 halt cleared", {7'd0, halted_o}, 8'h00);
        chk("R9 ime restored", {7'd0, ime_o}, 8'h01);
        rd(A_FLAG, d); chk("R9 flag kept", d, 8'h20);

        // R10: ime_clr, and check overriding ime_set and halt_req
        @(negedge clk); ime_clr = 1'b1;
        @(negedge clk); ime_clr = 1'b0;
        chk("R10 ime_clr lowers", {7'd0, ime_o}, 8'h00);
        wr(A_EN, 8'h01); wr(A_FLAG, 8'h01);
        pulse_ime_set();
        exp_q.push_back(8'h40);
        step(1'b1, 1'b1);
        chk("R10 check beats ime_set", {7'd0, ime_o}, 8'h00);
        chk("R10 check beats halt_req", {7'd0, halted_o}, 8'h00);

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 missing takes actual %0d expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule